// File: doc/BRIEF.md
# Conversion FIFO with Service Request

This block buffers converter results in a first-in first-out store and tells a host or DMA engine when the store needs service. Each conversion-done strobe carries one result word into the store. The host takes words out with a read strobe, and the oldest word is always on the read data port. The block reports occupancy, empty, full and half-full flags, plus a sticky overflow flag for results that were lost.

A mode input selects one of two request policies. In single-sample mode the request line is high whenever at least one word is waiting. In half-full mode the request has hysteresis: it rises once occupancy reaches half the depth and stays high until the store has been drained completely. Any change of the mode input drops the request for one cycle, and the request is then worked out again from the current occupancy.

The block also conditions an active-low external trigger. The trigger is synchronized, its falling edge is detected, and it is forwarded as a one-cycle start pulse. A disable input masks the trigger completely.

Top module: `conv_fifo_req`

## Requirements
- R1: With `halfMode` high, `svcReq` rises on the clock edge after occupancy reaches 256 (half of the 512-entry depth).
- R2: With `halfMode` high, once `svcReq` is high it stays high while occupancy is non-zero, including below 256, and it falls on the edge after occupancy reaches 0.
- R3: With `halfMode` low, `svcReq` rises on the clock edge after occupancy becomes 1 or more.
- R4: With `halfMode` low, `svcReq` falls on the clock edge after occupancy returns to 0.
- R5: Words leave in arrival order. `rdData` always shows the oldest word, a read strobe removes it, and a read strobe while empty changes nothing.
- R6: A conversion arriving while the store is full, with no read in the same cycle, is discarded. It sets `overflow`, which stays high until reset.
- R7: `fifoCount` gives occupancy; `fifoEmpty` means count 0, `fifoFull` means count 512, `fifoHalf` means count of at least 256. After reset the count is 0, `fifoEmpty` is high and every other output is low.
- R8: A falling edge on `extTrigN`, with `trigDisable` low, yields exactly one cycle of `trigStart` high, visible after the third rising clock edge following the change.
- R9: While `trigDisable` is high, `extTrigN` activity never raises `trigStart`.
- R10: A change of `halfMode` forces `svcReq` low on the following edge. After that the request is worked out again from occupancy, and in half-full mode a cleared request is not restored below 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| convValid | input | 1 | Conversion-done strobe |
| convData | input | 16 | Conversion result |
| rdStrobe | input | 1 | Host read strobe, removes the head word |
| halfMode | input | 1 | 1 = half-full request policy, 0 = single-sample policy |
| extTrigN | input | 1 | External trigger, active low, asynchronous |
| trigDisable | input | 1 | Masks the external trigger |
| rdData | output | 16 | Oldest stored word |
| fifoCount | output | 10 | Occupancy, 0 to 512 |
| fifoEmpty | output | 1 | Store empty |
| fifoFull | output | 1 | Store full |
| fifoHalf | output | 1 | Occupancy at least half of depth |
| overflow | output | 1 | Sticky lost-conversion flag |
| svcReq | output | 1 | Interrupt/DMA service request |
| trigStart | output | 1 | One-cycle acquisition start pulse |

## Verification
The hardest state to reach is the middle band of the half-full hysteresis. There, occupancy is between 1 and 255 and the request must still be high, because it reflects history and not the current count. The stimulus fills the store to exactly 255 and then 256 words, and drains it one word at a time down to 1 and then 0, checking the request at each boundary. The mode-change tests flip the mode while occupancy is 300 and again at 10. This shows both the forced one-cycle drop and the case where a cleared half-mode request is not restored below threshold.

// File: rtl/conv_fifo_pkg.sv
package conv_fifo_pkg;
  // Strobes from the control unit to the storage datapath
  typedef struct packed {
    logic push;
    logic pop;
  } fifoCtrl_t;

  // Request policy selected by the mode input
  typedef enum logic {
    POL_SINGLE = 1'b0,
    POL_HALF   = 1'b1
  } reqPolicy_t;
endpackage

// File: rtl/cfr_datapath.sv
module cfr_datapath
  import conv_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 512,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fifoCtrl_t         ctrl,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  count,
  output logic              isEmpty,
  output logic              isFull,
  output logic              isHalf
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;

  // Storage array: written on push, no reset needed
  always_ff @(posedge clk) begin
    if (ctrl.push) mem[wrPtr] <= wrData;
  end

  // Pointers wrap naturally because DEPTH is a power of two
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (ctrl.push) wrPtr <= wrPtr + 1'b1;
      if (ctrl.pop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      unique case ({ctrl.push, ctrl.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // Show-ahead read port
  assign rdData  = mem[rdPtr];
  assign isEmpty = (count == '0);
  assign isFull  = (count == FULL_CNT);
  assign isHalf  = (count >= HALF_CNT);
endmodule

// File: rtl/cfr_control.sv
module cfr_control
  import conv_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             convValid,
  input  logic             rdStrobe,
  input  logic             halfMode,
  input  logic             extTrigN,
  input  logic             trigDisable,
  input  logic [CNT_W-1:0] count,
  input  logic             isEmpty,
  input  logic             isFull,
  input  logic             isHalf,
  output fifoCtrl_t        ctrl,
  output logic             overflow,
  output logic             svcReq,
  output logic             trigStart
);
  // ---------------- FIFO strobes ----------------
  logic popOk;
  logic pushOk;
  logic dropSample;

  assign popOk      = rdStrobe && !isEmpty;
  assign pushOk     = convValid && (!isFull || popOk);
  assign dropSample = convValid && !pushOk;
  assign ctrl.push  = pushOk;
  assign ctrl.pop   = popOk;

  always_ff @(posedge clk) begin
    if (!rst_n)          overflow <= 1'b0;
    else if (dropSample) overflow <= 1'b1;
  end

  // ---------------- Request policy ----------------
  reqPolicy_t policy;
  reqPolicy_t policyQ;
  logic       modeChange;
  logic       reqNext;

  assign policy     = reqPolicy_t'(halfMode);
  assign modeChange = (policy != policyQ);

  always_comb begin
    reqNext = svcReq;
    if (modeChange) begin
      reqNext = 1'b0;
    end else begin
      unique case (policy)
        POL_SINGLE: reqNext = !isEmpty;
        POL_HALF: begin
          if (isHalf)       reqNext = 1'b1;
          else if (isEmpty) reqNext = 1'b0;
          else              reqNext = svcReq;
        end
        default: reqNext = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      policyQ <= POL_SINGLE;
      svcReq  <= 1'b0;
    end else begin
      policyQ <= policy;
      svcReq  <= reqNext;
    end
  end

  // ---------------- Trigger conditioning ----------------
  localparam int SYNC_STAGES = 2;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lastQ;
  logic                   fallSeen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncQ <= '1;
      lastQ <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], extTrigN};
      lastQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign fallSeen = lastQ && !syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) trigStart <= 1'b0;
    else        trigStart <= fallSeen && !trigDisable;
  end

  // Count feeds only the flag comparators in the datapath; kept here for width checks
  logic countUnusedBits;
  assign countUnusedBits = ^count;
endmodule

// File: rtl/conv_fifo_req.sv
module conv_fifo_req
  import conv_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 512,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              convValid,
  input  logic [DATA_W-1:0] convData,
  input  logic              rdStrobe,
  input  logic              halfMode,
  input  logic              extTrigN,
  input  logic              trigDisable,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  fifoCount,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic              fifoHalf,
  output logic              overflow,
  output logic              svcReq,
  output logic              trigStart
);
  fifoCtrl_t ctrl;

  cfr_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .convValid   (convValid),
    .rdStrobe    (rdStrobe),
    .halfMode    (halfMode),
    .extTrigN    (extTrigN),
    .trigDisable (trigDisable),
    .count       (fifoCount),
    .isEmpty     (fifoEmpty),
    .isFull      (fifoFull),
    .isHalf      (fifoHalf),
    .ctrl        (ctrl),
    .overflow    (overflow),
    .svcReq      (svcReq),
    .trigStart   (trigStart)
  );

  cfr_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl),
    .wrData  (convData),
    .rdData  (rdData),
    .count   (fifoCount),
    .isEmpty (fifoEmpty),
    .isFull  (fifoFull),
    .isHalf  (fifoHalf)
  );
endmodule

// File: rtl/cfr_checker.sv
module cfr_checker #(
  parameter int DEPTH = 512,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             convValid,
  input logic             rdStrobe,
  input logic             halfMode,
  input logic             trigDisable,
  input logic [CNT_W-1:0] fifoCount,
  input logic             fifoFull,
  input logic             overflow,
  input logic             svcReq,
  input logic             trigStart
);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  p_half_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halfMode) && $past(halfMode, 2) && ($past(fifoCount) >= HALF_CNT) |-> svcReq);

  p_half_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halfMode) && $past(halfMode, 2) && $past(svcReq) && ($past(fifoCount) != '0) |-> svcReq);

  p_single_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(halfMode) && !$past(halfMode, 2) |-> (svcReq == ($past(fifoCount) != '0)));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifoFull && convValid && !rdStrobe |=> overflow && $stable(fifoCount));

  p_sticky_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_one_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trigStart |=> !trigStart);

  p_trig_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trigDisable |=> !trigStart);

  p_mode_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (halfMode != $past(halfMode)) |=> !svcReq);
endmodule

bind conv_fifo_req cfr_checker #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .convValid   (convValid),
  .rdStrobe    (rdStrobe),
  .halfMode    (halfMode),
  .trigDisable (trigDisable),
  .fifoCount   (fifoCount),
  .fifoFull    (fifoFull),
  .overflow    (overflow),
  .svcReq      (svcReq),
  .trigStart   (trigStart)
);

// File: tb/test_conv_fifo_req.sv
`timescale 1ns/1ps
module test_conv_fifo_req;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 512;
  localparam int CNT_W  = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic convValid;
  logic [DATA_W-1:0] convData;
  logic rdStrobe;
  logic halfMode;
  logic extTrigN;
  logic trigDisable;
  logic [DATA_W-1:0] rdData;
  logic [CNT_W-1:0] fifoCount;
  logic fifoEmpty, fifoFull, fifoHalf, overflow, svcReq, trigStart;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  conv_fifo_req #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_conv_fifo_req (
    .clk(clk), .rst_n(rst_n), .convValid(convValid), .convData(convData),
    .rdStrobe(rdStrobe), .halfMode(halfMode), .extTrigN(extTrigN),
    .trigDisable(trigDisable), .rdData(rdData), .fifoCount(fifoCount),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .fifoHalf(fifoHalf),
    .overflow(overflow), .svcReq(svcReq), .trigStart(trigStart)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic mode);
    convValid = 0; convData = '0; rdStrobe = 0; halfMode = mode;
    extTrigN = 1; trigDisable = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic pushOne(input logic [DATA_W-1:0] d);
    convValid = 1; convData = d;
    @(negedge clk);
    convValid = 0;
  endtask

  task automatic popOne();
    rdStrobe = 1;
    @(negedge clk);
    rdStrobe = 0;
  endtask

  task automatic testReset();
    doReset(1'b0);
    check("R7 reset count", 32'(fifoCount), 0);
    check("R7 reset empty", 32'(fifoEmpty), 1);
    check("R7 reset full", 32'(fifoFull), 0);
    check("R7 reset half", 32'(fifoHalf), 0);
    check("R6 reset overflow", 32'(overflow), 0);
    check("R3 reset request", 32'(svcReq), 0);
    check("R8 reset trigger", 32'(trigStart), 0);
  endtask

  task automatic testSingle();
    doReset(1'b0);
    pushOne(16'hA001);
    check("R7 count after push", 32'(fifoCount), 1);
    check("R3 request not yet", 32'(svcReq), 0);
    @(negedge clk);
    check("R3 request raised", 32'(svcReq), 1);
    popOne();
    @(negedge clk);
    check("R4 request dropped", 32'(svcReq), 0);
    check("R7 empty again", 32'(fifoEmpty), 1);
  endtask

  task automatic testOrder();
    doReset(1'b0);
    popOne();
    check("R5 read on empty ignored", 32'(fifoCount), 0);
    pushOne(16'h1234);
    pushOne(16'h5678);
    pushOne(16'h9ABC);
    check("R5 head word", 32'(rdData), 32'h1234);
    popOne();
    check("R5 second word", 32'(rdData), 32'h5678);
    popOne();
    check("R5 third word", 32'(rdData), 32'h9ABC);
    check("R7 count after pops", 32'(fifoCount), 1);
  endtask

  task automatic testHalf();
    doReset(1'b1);
    for (int i = 0; i < DEPTH/2 - 1; i++) pushOne(DATA_W'(i));
    @(negedge clk);
    check("R1 below threshold", 32'(svcReq), 0);
    check("R7 half flag below", 32'(fifoHalf), 0);
    pushOne(16'h00FF);
    check("R7 half flag at 256", 32'(fifoHalf), 1);
    check("R1 not yet on edge", 32'(svcReq), 0);
    @(negedge clk);
    check("R1 raised at half", 32'(svcReq), 1);
    for (int i = 0; i < DEPTH/2 - 1; i++) popOne();
    @(negedge clk);
    check("R2 count at one", 32'(fifoCount), 1);
    check("R2 held with one word", 32'(svcReq), 1);
    popOne();
    check("R2 still high on drain edge", 32'(svcReq), 1);
    @(negedge clk);
    check("R2 dropped when empty", 32'(svcReq), 0);
  endtask

  task automatic testFull();
    doReset(1'b0);
    for (int i = 0; i < DEPTH; i++) pushOne(DATA_W'(i + 16'h0100));
    check("R7 full flag", 32'(fifoFull), 1);
    check("R6 no overflow yet", 32'(overflow), 0);
    pushOne(16'hDEAD);
    check("R6 overflow set", 32'(overflow), 1);
    check("R6 count unchanged", 32'(fifoCount), DEPTH);
    check("R6 head unchanged", 32'(rdData), 32'h0100);
    for (int i = 0; i < DEPTH - 1; i++) popOne();
    check("R6 dropped word absent", 32'(rdData), 32'(16'h0100 + DEPTH - 1));
    check("R6 overflow sticky", 32'(overflow), 1);
  endtask

  task automatic testModeChange();
    doReset(1'b0);
    for (int i = 0; i < 300; i++) pushOne(DATA_W'(i));
    @(negedge clk);
    check("R3 request with 300", 32'(svcReq), 1);
    halfMode = 1;
    @(negedge clk);
    check("R10 cleared on switch to half", 32'(svcReq), 0);
    @(negedge clk);
    check("R10 re-evaluated above half", 32'(svcReq), 1);
    for (int i = 0; i < 290; i++) popOne();
    check("R2 held at 10 words", 32'(svcReq), 1);
    halfMode = 0;
    @(negedge clk);
    check("R10 cleared on switch to single", 32'(svcReq), 0);
    @(negedge clk);
    check("R10 single re-evaluated", 32'(svcReq), 1);
    halfMode = 1;
    @(negedge clk);
    check("R10 cleared again", 32'(svcReq), 0);
    repeat (3) @(negedge clk);
    check("R10 half not restored below 256", 32'(svcReq), 0);
  endtask

  task automatic testTrigger();
    doReset(1'b0);
    extTrigN = 0;
    @(negedge clk);
    check("R8 edge 1", 32'(trigStart), 0);
    @(negedge clk);
    check("R8 edge 2", 32'(trigStart), 0);
    @(negedge clk);
    check("R8 pulse at edge 3", 32'(trigStart), 1);
    @(negedge clk);
    check("R8 pulse one cycle", 32'(trigStart), 0);
    repeat (3) @(negedge clk);
    check("R8 no pulse while low", 32'(trigStart), 0);
    extTrigN = 1;
    repeat (4) @(negedge clk);
    check("R8 no pulse on rise", 32'(trigStart), 0);
    trigDisable = 1;
    extTrigN = 0;
    begin
      logic seen = 1'b0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (trigStart) seen = 1'b1;
      end
      check("R9 masked trigger", 32'(seen), 0);
    end
  endtask

  initial begin
    testReset();
    testSingle();
    testOrder();
    testHalf();
    testFull();
    testModeChange();
    testTrigger();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule